// File: doc/BRIEF.md
# Successive-Approximation Converter Controller

This block is the digital sequencer of a 12-bit successive-approximation sampling converter. A falling edge on the active-low convert-start input, seen while chip select is low, starts a conversion. The block clears its trial register and then decides one bit per bit period, from the most significant bit down to the least significant bit. It reads a one-bit comparator decision from the analog front end at the end of each period. While the conversion runs, the busy flag is held low. The finished word is written into output latches in two's complement form, and busy returns high on the following cycle.

The latches drive a three-state data bus. The bus is enabled only when chip select and read are both low. The previous word stays readable until the new one replaces it, so there is no pipeline delay. A shutdown input puts the block into one of two low-power modes, chosen by a mode-select pin. Each mode has its own wake-up delay, and convert requests made before the block is awake again are dropped.

Top module: `sar_ctrl`

## Requirements
- R1: A conversion starts at the first clock edge that samples convert-start low after it was sampled high, provided chip select is low at that edge. The same edge with chip select high starts nothing, and busy stays high.
- R2: Convert-start falling edges during a running conversion are ignored. Busy is not extended and the result is not disturbed.
- R3: At the start of a conversion the trial register is cleared and the MSB is set. The trial code on `trial` is offset binary. Each tested bit is kept when `cmp_hi` is 1 (input at or above the trial code) and cleared otherwise, going from bit NBITS-1 down to bit 0.
- R4: The new word is in the output latches one clock before busy returns high.
- R5: `dbus` carries the latched word when `cs_n` and `rd_n` are both low, and is high impedance otherwise.
- R6: During a conversion, `dbus` presents the previous result. After reset the latched word is 0 and busy is high.
- R7: The output word is two's complement, which is the offset-binary code with its MSB inverted. So 0x7FF is the largest positive value, 0xFFF is the code just below zero, and 0x800 is the most negative value.
- R8: While `shdn_n` is low, no conversion can start. `nap_sel` high selects nap mode and low selects sleep mode.
- R9: After `shdn_n` returns high, the block needs NAP_WAKE_CYC clock cycles (nap) or SLEEP_WAKE_CYC clock cycles (sleep) before it accepts a start. Earlier requests are ignored and do not lower busy.
- R10: Each bit period lasts BIT_CYC clocks and samples the comparator once at its end. Busy is low for exactly NBITS*BIT_CYC+1 clock cycles per conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| convst_n | input | 1 | Convert start, falling edge starts a conversion |
| rd_n | input | 1 | Read enable for the data bus, active low |
| shdn_n | input | 1 | Low requests power-down |
| nap_sel | input | 1 | Power-down mode: 1 nap, 0 sleep |
| cmp_hi | input | 1 | Comparator: input is at or above the trial code |
| trial | output | NBITS | Offset-binary trial code to the DAC |
| busy_n | output | 1 | Low while a conversion is in progress |
| dbus | output | NBITS | Three-state result bus |

## Verification
The checker assumes that convert-start and chip select are synchronous to the clock and that `cmp_hi` is a function of the present trial code. The bench drives every input on the falling clock edge and models the comparator combinationally from a fixed target held for the whole conversion. Shutdown is only toggled while busy is high, so the length and start properties never see a conversion that overlaps a power-down.

// File: rtl/sar_ctrl.sv
module sar_ctrl #(
  parameter int NBITS          = 12,
  parameter int BIT_CYC        = 5,
  parameter int NAP_WAKE_CYC   = 20,
  parameter int SLEEP_WAKE_CYC = 2000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             convst_n,
  input  logic             rd_n,
  input  logic             shdn_n,
  input  logic             nap_sel,
  input  logic             cmp_hi,
  output logic [NBITS-1:0] trial,
  output logic             busy_n,
  output logic [NBITS-1:0] dbus
);

  localparam int IW   = (NBITS > 1) ? $clog2(NBITS) : 1;
  localparam int PW   = (BIT_CYC > 1) ? $clog2(BIT_CYC) : 1;
  localparam int WMAX = (SLEEP_WAKE_CYC > NAP_WAKE_CYC) ? SLEEP_WAKE_CYC : NAP_WAKE_CYC;
  localparam int WW   = $clog2(WMAX + 1);
  localparam logic [NBITS-1:0] MSB_ONLY = {1'b1, {(NBITS-1){1'b0}}};

  typedef enum logic [1:0] {S_IDLE, S_CONV, S_FIN} phase_t;

  phase_t           phase_q;
  logic             convst_q;
  logic [NBITS-1:0] sar_q, result_q;
  logic [IW-1:0]    idx_q;
  logic [PW-1:0]    per_q;
  logic [WW-1:0]    wake_q;

  logic             awake, start, per_end;
  logic [NBITS-1:0] bit_mask, decided;

  assign awake    = shdn_n && (wake_q == '0);
  assign start    = !cs_n && convst_q && !convst_n && awake && (phase_q == S_IDLE);
  assign bit_mask = {{(NBITS-1){1'b0}}, 1'b1} << idx_q;
  assign decided  = cmp_hi ? (sar_q | bit_mask) : sar_q;
  assign per_end  = (per_q == PW'(BIT_CYC - 1));
  assign trial    = (phase_q == S_CONV) ? (sar_q | bit_mask) : sar_q;
  assign busy_n   = (phase_q == S_IDLE);
  assign dbus     = (!cs_n && !rd_n) ? result_q : 'z;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) convst_q <= 1'b1;
    else        convst_q <= convst_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      wake_q <= '0;
    else if (!shdn_n)
      wake_q <= nap_sel ? WW'(NAP_WAKE_CYC) : WW'(SLEEP_WAKE_CYC);
    else if (wake_q != '0)
      wake_q <= wake_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= S_IDLE;
      sar_q    <= '0;
      result_q <= '0;
      idx_q    <= '0;
      per_q    <= '0;
    end else begin
      case (phase_q)
        S_IDLE: if (start) begin
          phase_q <= S_CONV;
          sar_q   <= '0;
          idx_q   <= IW'(NBITS - 1);
          per_q   <= '0;
        end
        S_CONV: if (per_end) begin
          per_q <= '0;
          sar_q <= decided;
          if (idx_q == '0) begin
            result_q <= decided ^ MSB_ONLY;
            phase_q  <= S_FIN;
          end else begin
            idx_q <= idx_q - 1'b1;
          end
        end else begin
          per_q <= per_q + 1'b1;
        end
        S_FIN:   phase_q <= S_IDLE;
        default: phase_q <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sar_ctrl_chk.sv
module sar_ctrl_chk #(
  parameter int NBITS   = 12,
  parameter int BIT_CYC = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             convst_n,
  input logic             shdn_n,
  input logic             awake,
  input logic             busy_n,
  input logic [NBITS-1:0] trial,
  input logic [NBITS-1:0] result
);
  localparam int LEN = NBITS * BIT_CYC + 1;
  localparam int CW  = $clog2(LEN + 2);
  localparam logic [NBITS-1:0] MSB_ONLY = {1'b1, {(NBITS-1){1'b0}}};

  logic [CW-1:0] low_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      low_cnt <= '0;
    else if (busy_n) low_cnt <= '0;
    else             low_cnt <= low_cnt + 1'b1;
  end

  a_r1_start_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_n) |-> ($past(cs_n) == 1'b0 && $past(convst_n) == 1'b0));
  a_r3_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_n) |-> trial == MSB_ONLY);
  a_r4_latched_before_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_n) |-> $stable(result));
  a_r6_result_held_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_n && $past(busy_n)) |-> $stable(result));
  a_r8_no_start_in_shdn: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_n) |-> $past(shdn_n));
  a_r9_start_only_awake: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_n) |-> $past(awake));
  a_r10_conv_length: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_n) |-> low_cnt == CW'(LEN));
  a_r2_no_stretch: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_n |-> low_cnt <= CW'(LEN));
endmodule

bind sar_ctrl sar_ctrl_chk #(.NBITS(NBITS), .BIT_CYC(BIT_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .convst_n(convst_n), .shdn_n(shdn_n),
  .awake(awake), .busy_n(busy_n), .trial(trial), .result(result_q)
);

// File: tb/sar_ctrl_tb.sv
module sar_ctrl_tb;
  localparam int NB    = 12;
  localparam int BC    = 5;
  localparam int NAPW  = 20;
  localparam int SLPW  = 2000;
  localparam int LEN   = NB * BC + 1;
  localparam int NVEC  = 8;
  localparam logic [NB-1:0] VEC [NVEC] = '{12'h7FF, 12'h800, 12'hFFF, 12'h000,
                                          12'h5A3, 12'hA5C, 12'h001, 12'h3C0};

  logic clk = 0, rst_n = 0, cs_n = 0, convst_n = 1, rd_n = 0, shdn_n = 1, nap_sel = 1;
  logic [NB-1:0] tgt = '0, prev = '0;
  logic [NB-1:0] trial, dbus;
  logic busy_n, cmp_hi;
  int n_vec = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;
  assign cmp_hi = ((tgt ^ 12'h800) >= trial);

  sar_ctrl #(.NBITS(NB), .BIT_CYC(BC), .NAP_WAKE_CYC(NAPW), .SLEEP_WAKE_CYC(SLPW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .convst_n(convst_n), .rd_n(rd_n),
    .shdn_n(shdn_n), .nap_sel(nap_sel), .cmp_hi(cmp_hi), .trial(trial),
    .busy_n(busy_n), .dbus(dbus));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse();
    @(negedge clk) convst_n = 0;
    @(negedge clk) convst_n = 1;
  endtask

  // full conversion; optional restart attempt inside it (R2), previous-word check (R6)
  task automatic convert(logic [NB-1:0] t, bit restart, string req);
    int cnt = 0;
    tgt = t;
    pulse();
    chk({req, " busy low after start"}, {31'd0, busy_n}, 32'd0);
    while (busy_n === 1'b0 && cnt < 1000) begin
      cnt++;
      if (restart) convst_n = (cnt == 10) ? 1'b0 : 1'b1;
      if (cnt == 20) chk("R6 previous word during conversion", {20'd0, dbus}, {20'd0, prev});
      @(negedge clk);
    end
    convst_n = 1;
    chk("R10 busy length", cnt, LEN);
    chk({req, " result"}, {20'd0, dbus}, {20'd0, t});
    prev = t;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    if (!done) $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R6 reset busy", {31'd0, busy_n}, 32'd1);
    chk("R6 reset word", {20'd0, dbus}, 32'd0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NVEC; i++) convert(VEC[i], 1'b0, "R7 R3 vector");

    convert(12'h456, 1'b1, "R2 restart ignored");

    // R1: edge with chip select high
    cs_n = 1; pulse();
    chk("R1 no start with cs high", {31'd0, busy_n}, 32'd1);
    @(negedge clk); chk("R1 still idle", {31'd0, busy_n}, 32'd1);
    cs_n = 0;

    // R5: bus release
    rd_n = 1; #1;
    chk("R5 z when rd high", {31'd0, (dbus === 12'hzzz)}, 32'd1);
    rd_n = 0; cs_n = 1; #1;
    chk("R5 z when cs high", {31'd0, (dbus === 12'hzzz)}, 32'd1);
    cs_n = 0; #1;
    chk("R5 driven when both low", {20'd0, dbus}, {20'd0, prev});

    // R8/R9 nap
    nap_sel = 1; shdn_n = 0;
    repeat (3) @(negedge clk);
    pulse(); chk("R8 no start in nap", {31'd0, busy_n}, 32'd1);
    shdn_n = 1;
    repeat (2) @(negedge clk);
    pulse(); chk("R9 early start in nap wake", {31'd0, busy_n}, 32'd1);
    repeat (NAPW + 2) @(negedge clk);
    convert(12'h123, 1'b0, "R9 nap wake start");

    // R8/R9 sleep
    nap_sel = 0; shdn_n = 0;
    repeat (3) @(negedge clk);
    pulse(); chk("R8 no start in sleep", {31'd0, busy_n}, 32'd1);
    shdn_n = 1;
    repeat (NAPW + 10) @(negedge clk);
    pulse(); chk("R9 sleep needs longer wake", {31'd0, busy_n}, 32'd1);
    chk("R9 word kept over sleep", {20'd0, dbus}, 32'h123);
    repeat (SLPW) @(negedge clk);
    convert(12'hE01, 1'b0, "R9 sleep wake start");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule